// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address. It does this by reading page-table entries from memory, one word at a time, through a simple request/acknowledge port. The walk begins at a context table, which is located by a root pointer and a context number. It then follows pointer entries through up to three directory levels. A leaf entry may appear at level 1 (16 MB page), level 2 (256 KB page) or level 3 (4 KB page). The leaf's 3-bit permission field is checked against the kind of access. On success, the leaf's referenced and modified flags are brought up to date, and the entry is written back only when one of them changes.

A requester offers one translation at a time, and only while `done` is high. When `done` returns, the block presents one of two outcomes. A translation gives the physical address, the permissions (read, write and execute) and the page size. A fault leaves `ok` low and updates a fault status register and a fault address register, which hold their values for software to read. Physical-mode requests bypass the walk. In boot mode, a physical-mode instruction fetch is redirected into a PROM window.

Top module: `pgwalk3`

## Requirements
- R1: The first read of a walk is at (ctx_root << 4) + (ctx_num << 2), zero-extended to 36 bits.
- R2: Entry type is bits [1:0]: 0 invalid, 1 pointer, 2 leaf, 3 reserved. A pointer's next read is at ({entry[31:2], 2'b00} << 4) plus 4 times a virtual-address index. The index is VA[31:24] at level 1, VA[23:18] at level 2 and VA[17:12] at level 3.
- R3: A leaf at level 1, 2 or 3 reports pg_size 1, 2 or 3. Its physical address is (entry[31:8] << 12) plus a page offset. The offset is VA[23:12] << 12 at level 1, VA[17:12] << 12 at level 2, and 0 at level 3.
- R4: Structural faults set fsr[9:8] to the level of the entry that was read and fsr[4:2] to a type. Type 1 is an invalid entry. Type 4 is any of the following: a read with mem_err, a reserved entry, a leaf at the context level, or a pointer at level 3.
- R5: The access index is {store, fetch, supervisor}, where req_kind 0 is a load, 1 a store and 2 a fetch. The leaf permission field is bits [4:2]. The grants for each value are:

  | Field value | User grant | Supervisor grant |
  |---|---|---|
  | 0 | R | R |
  | 1 | RW | RW |
  | 2 | RX | RX |
  | 3 | RWX | RWX |
  | 4 | X | X |
  | 5 | R | RW |
  | 6 | none | RX |
  | 7 | none | RWX |

  A user access to field 6 or 7 faults with type 3. Otherwise, an access needing a permission that is not granted faults with type 2. Both report the leaf level in fsr[9:8].
- R6: With nofault set, a permission fault on a user access is suppressed, and the translation completes with ok high. For a supervisor access, the fault still occurs.
- R7: On success, entry bit 5 (referenced) is set, and a store also sets bit 6 (modified). The entry is written back to its own address only if its value changed.
- R8: perm is {R, W, X}. W is reported only when the leaf, after update, has bit 6 set.
- R9: On a fault, fsr is first set to 1 if it was nonzero, then ORed with (access index << 5) | code | 2. far receives the VA with bits [11:0] cleared. A pulse on fsr_clr with no fault in the same cycle clears fsr.
- R10: A request with req_phys set does no memory access. With boot_mode set and a fetch, pa is prom_base | VA[18:0] and perm is 101. Otherwise pa is the page-aligned VA and perm is 111.
- R11: done is low while a walk is in progress. A request is taken only when done is high. mem_req stays high with a stable address until mem_ack.
- R12: After reset, done is high, ok is low, fsr is 0 and mem_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a translation (taken when done is high) |
| req_va | input | 32 | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_super | input | 1 | Supervisor access |
| req_phys | input | 1 | Physical mode, no walk |
| ctx_root | input | 32 | Context table pointer |
| ctx_num | input | CTX_W | Context number |
| nofault | input | 1 | Suppress user permission faults |
| boot_mode | input | 1 | Redirect physical fetches to PROM |
| prom_base | input | 36 | PROM window base |
| fsr_clr | input | 1 | Clear fault status |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write-back |
| mem_addr | output | 36 | Word address (byte units) |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Bus error, valid with mem_ack |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| done | output | 1 | Idle and results valid |
| ok | output | 1 | Last request translated |
| pa | output | 36 | Physical address |
| perm | output | 3 | {R, W, X} |
| pg_size | output | 2 | Leaf level (1: 16 MB, 2: 256 KB, 3: 4 KB) |
| fsr | output | 10 | Fault status |
| far | output | 32 | Fault address |

## Verification
The bench builds real tables in a sparse memory model and aims at the following corner cases:
- **Leaves at every level.** A walker that mixes up the level-specific VA slices would read the wrong entry or add a wrong page offset.
- **Write-permission rule.** A load to an unmodified page must withhold W, while a following store must set both flags and grant W. A design that writes back on every hit would show up in a write counter.
- **Fault code composition.** Faults at each level, of each type, and a second fault with no clear in between are checked. This exposes any lost overflow reload or misplaced access index.
- **No-fault and boot paths.** The no-fault case checks that only user permission faults are suppressed. The boot path must redirect fetches alone.

// File: rtl/pgwalk3.sv
module pgwalk3 #(
  parameter int CTX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [31:0]      req_va,
  input  logic [1:0]       req_kind,
  input  logic             req_super,
  input  logic             req_phys,
  input  logic [31:0]      ctx_root,
  input  logic [CTX_W-1:0] ctx_num,
  input  logic             nofault,
  input  logic             boot_mode,
  input  logic [35:0]      prom_base,
  input  logic             fsr_clr,
  output logic             mem_req,
  output logic             mem_we,
  output logic [35:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic             mem_err,
  input  logic [31:0]      mem_rdata,
  output logic             done,
  output logic             ok,
  output logic [35:0]      pa,
  output logic [2:0]       perm,
  output logic [1:0]       pg_size,
  output logic [9:0]       fsr,
  output logic [31:0]      far
);
  localparam int REF_B = 5;
  localparam int MOD_B = 6;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;
  st_t         st;
  logic [1:0]  lvl;
  logic [31:0] va_q;
  logic [1:0]  kind_q;
  logic        sup_q;
  logic [31:0] ent;
  logic [35:0] addr_q;

  assign done      = (st == S_IDLE);
  assign mem_req   = (st != S_IDLE);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = addr_q;
  assign mem_wdata = ent;

  wire [1:0]  ety     = mem_rdata[1:0];
  wire [2:0]  acc     = mem_rdata[4:2];
  wire        is_ptr  = (ety == 2'd1) && (lvl != 2'd3);
  wire        is_leaf = (ety == 2'd2) && (lvl != 2'd0);
  wire [2:0]  aidx    = {kind_q[0], kind_q[1], sup_q};
  wire [31:0] upd     = mem_rdata | (32'd1 << REF_B) | (kind_q[0] ? (32'd1 << MOD_B) : 32'd0);
  wire [31:0] va_m    = {req_va[31:12], 12'h000};

  logic [9:0]  vidx;
  logic [35:0] offs;
  logic [2:0]  grant, need, pcode, stype;
  always_comb begin
    case (lvl)
      2'd0:    vidx = {va_q[31:24], 2'b00};
      2'd1:    vidx = {2'b00, va_q[23:18], 2'b00};
      default: vidx = {2'b00, va_q[17:12], 2'b00};
    endcase
    case (lvl)
      2'd1:    offs = {12'd0, va_q[23:12], 12'd0};
      2'd2:    offs = {18'd0, va_q[17:12], 12'd0};
      default: offs = 36'd0;
    endcase
    grant[2] = sup_q ? (acc != 3'd4) : (acc != 3'd4 && acc != 3'd6 && acc != 3'd7);
    grant[1] = (acc == 3'd1) || (acc == 3'd3) || (sup_q && (acc == 3'd5 || acc == 3'd7));
    grant[0] = (acc == 3'd2) || (acc == 3'd3) || (acc == 3'd4) || (sup_q && acc[2] && acc[1]);
    need     = {~(kind_q[0] | kind_q[1]), kind_q[0], kind_q[1]};
    if (!sup_q && acc[2] && acc[1])   pcode = 3'd3;
    else if ((need & ~grant) != 3'd0) pcode = 3'd2;
    else                              pcode = 3'd0;
    stype = (!mem_err && ety == 2'd0) ? 3'd1 : 3'd4;
  end

  wire rd_ack   = (st == S_RD) && mem_ack;
  wire sfault   = rd_ack && (mem_err || (!is_ptr && !is_leaf));
  wire pfault   = rd_ack && !sfault && is_leaf && (pcode != 3'd0) && !(nofault && !sup_q);
  wire flt_now  = sfault || pfault;
  wire [2:0]  ftype = sfault ? stype : pcode;
  wire [9:0]  fsr_n = ((fsr != 10'd0) ? 10'd1 : 10'd0) | {lvl, 8'd0}
                    | {2'd0, aidx, 5'd0} | {5'd0, ftype, 2'd0} | 10'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; lvl <= 2'd0; va_q <= '0; kind_q <= '0; sup_q <= 1'b0;
      ent <= '0; addr_q <= '0; ok <= 1'b0; pa <= '0; perm <= '0;
      pg_size <= '0; fsr <= '0; far <= '0;
    end else begin
      if (flt_now) begin
        fsr <= fsr_n;
        far <= va_q;
      end else if (fsr_clr) begin
        fsr <= '0;
      end
      case (st)
        S_IDLE: if (req_valid) begin
          va_q <= va_m; kind_q <= req_kind; sup_q <= req_super; ok <= 1'b0;
          if (req_phys) begin
            ok      <= 1'b1;
            pg_size <= 2'd3;
            if (boot_mode && req_kind[1]) begin
              pa   <= prom_base | {17'd0, va_m[18:0]};
              perm <= 3'b101;
            end else begin
              pa   <= {4'd0, va_m};
              perm <= 3'b111;
            end
          end else begin
            st     <= S_RD;
            lvl    <= 2'd0;
            addr_q <= {ctx_root, 4'd0} + {{(34-CTX_W){1'b0}}, ctx_num, 2'b00};
          end
        end
        S_RD: if (mem_ack) begin
          if (flt_now) begin
            st <= S_IDLE;
          end else if (is_ptr) begin
            lvl    <= lvl + 2'd1;
            addr_q <= {mem_rdata[31:2], 6'd0} + {26'd0, vidx};
          end else begin
            ok      <= 1'b1;
            pa      <= {mem_rdata[31:8], 12'd0} + offs;
            perm    <= grant & {1'b1, upd[MOD_B], 1'b1};
            pg_size <= lvl;
            ent     <= upd;
            st      <= (upd != mem_rdata) ? S_WR : S_IDLE;
          end
        end
        S_WR: if (mem_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11: request held steady until acknowledged
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  // R7: write-back goes to the address of the leaf just read
  a_r7_wb_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $stable(mem_addr));
  // R8: write permission only with the modified flag in the stored entry
  a_r8_w_mod: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) && perm[1] |-> mem_wdata[MOD_B]);
  // R9: any nonzero status carries the fault-valid bit
  a_r9_fsr_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fsr != 10'd0 |-> fsr[1]);
  // R12: after a reset, idle with no request
  a_r12_idle: assert property (@(posedge clk)
    !rst_n |=> done && !mem_req && !ok);
endmodule

// File: tb/sim_pgwalk3.sv
module sim_pgwalk3;
  localparam time CLK_P = 10ns;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_super = 0, req_phys = 0;
  logic [31:0] req_va = 0;
  logic [1:0]  req_kind = 0;
  logic [31:0] ctx_root = 32'h1000;
  logic [7:0]  ctx_num = 8'd2;
  logic nofault = 0, boot_mode = 0, fsr_clr = 0;
  logic [35:0] prom_base = 36'hFF0000000;
  logic mem_req, mem_we, mem_ack, mem_err, done, ok;
  logic [35:0] mem_addr, pa;
  logic [31:0] mem_wdata, mem_rdata, far;
  logic [2:0]  perm;
  logic [1:0]  pg_size;
  logic [9:0]  fsr;

  always #(CLK_P/2) clk = ~clk;

  pgwalk3 #(.CTX_W(8)) u0 (.*);

  logic [31:0] mem [logic [35:0]];
  logic [35:0] err_addr = '1;
  logic ack_r = 0, err_r = 0;
  logic [31:0] rd_r = 0;
  int wr_cnt = 0, n_chk = 0, n_bad = 0;
  bit saw_busy;
  assign mem_ack = ack_r;
  assign mem_err = err_r;
  assign mem_rdata = rd_r;

  always @(posedge clk) begin
    if (!rst_n) ack_r <= 0;
    else begin
      ack_r <= mem_req && !ack_r;
      if (mem_req && !ack_r) begin
        rd_r  <= mem.exists(mem_addr) ? mem[mem_addr] : 32'd0;
        err_r <= (mem_addr == err_addr);
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          wr_cnt++;
        end
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic go(logic [31:0] va, logic [1:0] kind, logic sup, logic phys);
    while (!done) @(negedge clk);
    req_va = va; req_kind = kind; req_super = sup; req_phys = phys; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    saw_busy = !done;
    while (!done) @(negedge clk);
  endtask

  task automatic clr;
    @(negedge clk); fsr_clr = 1;
    @(negedge clk); fsr_clr = 0;
  endtask

  task automatic t_reset;
    chk("R12 done", done, 1); chk("R12 ok", ok, 0);
    chk("R12 fsr", fsr, 0);   chk("R12 mem_req", mem_req, 0);
  endtask

  task automatic t_small;
    int w0;
    go(32'h12345000, 2'd0, 0, 0);
    chk("R11 busy during walk", saw_busy, 1);
    chk("R1 R2 ok", ok, 1);
    chk("R3 pa 4KB", pa, 36'h0ABCDE000);
    chk("R3 size", pg_size, 3);
    chk("R8 no W before modified", perm, 3'b101);
    chk("R7 ref written", mem[36'h40014], 32'h0ABCDE2E);
    go(32'h12345000, 2'd1, 0, 0);
    chk("R7 store sets modified", mem[36'h40014], 32'h0ABCDE6E);
    chk("R8 W after store", perm, 3'b111);
    w0 = wr_cnt;
    go(32'h12345000, 2'd0, 0, 0);
    chk("R7 no write when unchanged", wr_cnt, w0);
    chk("R8 perm RWX", perm, 3'b111);
  endtask

  task automatic t_large;
    go(32'h56789000, 2'd0, 1, 0);
    chk("R3 pa 16MB", pa, 36'h0C0789000);
    chk("R3 size 16MB", pg_size, 1);
    chk("R8 perm R only", perm, 3'b100);
    go(32'h12383000, 2'd2, 0, 0);
    chk("R3 pa 256KB", pa, 36'h0D0003000);
    chk("R3 size 256KB", pg_size, 2);
    chk("R5 fetch RX", perm, 3'b101);
  endtask

  task automatic t_struct;
    clr();
    go(32'h12400123, 2'd0, 0, 0);
    chk("R4 invalid ok", ok, 0);
    chk("R4 invalid L2 fsr", fsr, 10'h206);
    chk("R9 far aligned", far, 32'h12400000);
    err_addr = 36'h40014;
    go(32'h12345000, 2'd1, 0, 0);
    chk("R9 overflow + bus error L3", fsr, 10'h393);
    err_addr = '1;
    clr();
    chk("R9 clear", fsr, 0);
    ctx_num = 8'd3;
    go(32'h12345000, 2'd0, 1, 0);
    chk("R4 reserved at context", fsr, 10'h032);
    ctx_num = 8'd2;
    clr();
    go(32'h12346000, 2'd0, 0, 0);
    chk("R4 pointer at L3", fsr, 10'h312);
  endtask

  task automatic t_perm;
    clr();
    go(32'h12347000, 2'd0, 0, 0);
    chk("R5 privilege code", fsr, 10'h30E);
    chk("R5 entry untouched", mem[36'h4001C], 32'h0ABCD01A);
    clr();
    go(32'h12383000, 2'd1, 0, 0);
    chk("R5 protection code", fsr, 10'h28A);
  endtask

  task automatic t_nofault;
    nofault = 1;
    clr();
    go(32'h12347000, 2'd0, 0, 0);
    chk("R6 user suppressed ok", ok, 1);
    chk("R6 pa", pa, 36'h0ABCD0000);
    chk("R6 perm none", perm, 3'b000);
    chk("R6 no status", fsr, 0);
    go(32'h12348000, 2'd2, 1, 0);
    chk("R6 supervisor still faults", ok, 0);
    chk("R6 supervisor fsr", fsr, 10'h36A);
    nofault = 0;
  endtask

  task automatic t_phys;
    int w0;
    w0 = wr_cnt;
    boot_mode = 1;
    go(32'h0007A123, 2'd2, 1, 1);
    chk("R10 boot pa", pa, 36'hFF007A000);
    chk("R10 boot perm", perm, 3'b101);
    go(32'h89ABC123, 2'd0, 1, 1);
    chk("R10 load pa", pa, 36'h089ABC000);
    chk("R10 load perm", perm, 3'b111);
    boot_mode = 0;
    go(32'h0007A000, 2'd2, 1, 1);
    chk("R10 no boot pa", pa, 36'h00007A000);
    chk("R10 no memory traffic", wr_cnt, w0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    mem[36'h10008] = 32'h00002001;
    mem[36'h1000C] = 32'h00000003;
    mem[36'h20048] = 32'h00003001;
    mem[36'h20158] = 32'h0C000006;
    mem[36'h30034] = 32'h00004001;
    mem[36'h30038] = 32'h0D00000A;
    mem[36'h40014] = 32'h0ABCDE0E;
    mem[36'h40018] = 32'h00004001;
    mem[36'h4001C] = 32'h0ABCD01A;
    mem[36'h40020] = 32'h0ABCC016;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_small();
    t_large();
    t_struct();
    t_perm();
    t_nofault();
    t_phys();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule